// File: doc/BRIEF.md
# Boot Device Priority Sequencer

After reset this controller walks a fixed ranking of four boot sources and asks each source's probe engine, one at a time, whether that source carries a valid boot signature. The first source that answers "bootable" wins, and no source ranked below it is asked. A strap input removes the serial-port source from the walk, so the search begins one rank lower.

Once a winner is known, the controller makes the handoff decision. Sources whose image must live in internal RAM get a copy-engine start pulse, and the controller waits for the copy to finish. Execution then begins at the RAM entry address. The parallel flash source is executed in place instead: nothing is copied, the entry address sits just past its signature word, and the bus width decoded from that signature is passed along. A probe that never answers is cut off by a timeout and counts as not bootable. When every source fails, the controller stops in a terminal failure state.

Top module: `boot_source_sequencer`

## Requirements
- R1: Sources are probed in the order serial port, SPI flash, parallel (NOR) flash, NAND flash. They are encoded 0, 1, 2 and 3, and source k is requested on `probe_req[k]`. At most one request is high at a time, and there is at least one idle cycle between two requests.
- R2: When `uart_boot_off` is high at reset release, `probe_req[0]` is never raised and the first probe goes to SPI (1).
- R3: The first source whose `probe_done` and `probe_valid` are high together while it is requested is selected, and no later source is probed. `probe_done`/`probe_valid` bits of sources that are not currently requested have no effect.
- R4: A request that gets no `probe_done` is held for exactly `PROBE_TIMEOUT` cycles, then dropped, and the source is treated as not bootable.
- R5: For a selected serial, SPI or NAND source, `copy_start` pulses for one cycle. `start_exec` waits for `copy_done`. `exec_addr` is 0x00000000 and `boot_width` is 32.
- R6: For a selected NOR source, `copy_start` never pulses and `exec_addr` is 0xE0000004. `probe_width` is sampled with the valid answer: code 0 gives 8, 1 gives 16, 2 gives 32 on `boot_width`. Code 3 makes the answer count as not bootable.
- R7: `start_exec` is high for exactly one cycle, exactly once per boot. It rises in the cycle after the NOR valid answer, or in the cycle after `copy_done`. From then on `sel_src`, `exec_addr` and `boot_width` hold their values until reset.
- R8: If no source is bootable, `boot_fail` rises after the last probe and stays high. From then on `probe_req` stays 0 and `start_exec` never pulses.
- R9: During reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| uart_boot_off | input | 1 | Strap: skip the serial-port source |
| probe_req | output | 4 | One-hot probe request per source |
| probe_done | input | 4 | Probe finished, per source |
| probe_valid | input | 4 | Signature valid, qualified by probe_done |
| probe_width | input | 2 | NOR bus-width code from the signature |
| copy_start | output | 1 | One-cycle pulse starting the copy to RAM |
| copy_done | input | 1 | Copy engine finished |
| sel_src | output | 2 | Selected source code |
| exec_addr | output | 32 | Execution entry address |
| boot_width | output | 6 | Boot bus width in bits |
| start_exec | output | 1 | One-cycle handoff pulse |
| boot_fail | output | 1 | No bootable source found |

## Verification
The bench builds the block with `PROBE_TIMEOUT` set to 12, so a silent probe is cut off within a few cycles. This lets timeout fallthrough be mixed with invalid answers and late valid answers in the same boot. It also lets the exact request length of a timed-out source be measured against the parameter. With every other value at its default, the walk through all four sources, including the terminal failure, fits in a short directed run.

// File: rtl/bootseq_pkg.sv
package bootseq_pkg;

  localparam int NSRC  = 4;
  localparam int SRC_W = $clog2(NSRC);

  typedef enum logic [SRC_W-1:0] {
    SRC_UART = 2'd0,
    SRC_SPI  = 2'd1,
    SRC_NOR  = 2'd2,
    SRC_NAND = 2'd3
  } src_e;

  typedef enum logic [2:0] {
    ST_INIT,
    ST_PROBE,
    ST_GAP,
    ST_COPY_GO,
    ST_COPY_WAIT,
    ST_HANDOFF,
    ST_DONE,
    ST_FAIL
  } seq_state_e;

  // Source executed in place rather than copied into RAM.
  function automatic logic runs_in_place(src_e s);
    return s == SRC_NOR;
  endfunction

  // Bus width code from the in-place signature: 0->8, 1->16, 2->32, 3 illegal.
  function automatic logic width_code_ok(logic [1:0] code);
    return code != 2'd3;
  endfunction

  function automatic logic [5:0] width_bits(logic [1:0] code);
    case (code)
      2'd0:    return 6'd8;
      2'd1:    return 6'd16;
      2'd2:    return 6'd32;
      default: return 6'd0;
    endcase
  endfunction

  function automatic src_e first_source(logic skip_serial);
    return skip_serial ? SRC_SPI : SRC_UART;
  endfunction

endpackage

// File: rtl/bseq_probe_timer.sv
module bseq_probe_timer #(
  parameter int LIMIT = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= '0;
    else if (!run)        cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  // High in the LIMIT-th consecutive cycle of run.
  assign expired = run && (cnt == LAST);

  AST_TMR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);  // R4
  AST_TMR_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt == '0);  // R4

endmodule

// File: rtl/bseq_sig_check.sv
module bseq_sig_check
  import bootseq_pkg::*;
(
  input  src_e       src,
  input  logic       valid,
  input  logic [1:0] width_code,
  output logic       bootable,
  output logic [5:0] width_out
);
  always_comb begin
    bootable  = valid && (!runs_in_place(src) || width_code_ok(width_code));
    width_out = runs_in_place(src) ? width_bits(width_code) : 6'd32;
  end
endmodule

// File: rtl/boot_source_sequencer.sv
module boot_source_sequencer
  import bootseq_pkg::*;
#(
  parameter int          PROBE_TIMEOUT = 4096,
  parameter logic [31:0] RAM_ENTRY     = 32'h0000_0000,
  parameter logic [31:0] XIP_ENTRY     = 32'hE000_0004
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            uart_boot_off,
  output logic [NSRC-1:0] probe_req,
  input  logic [NSRC-1:0] probe_done,
  input  logic [NSRC-1:0] probe_valid,
  input  logic [1:0]      probe_width,
  output logic            copy_start,
  input  logic            copy_done,
  output logic [SRC_W-1:0] sel_src,
  output logic [31:0]     exec_addr,
  output logic [5:0]      boot_width,
  output logic            start_exec,
  output logic            boot_fail
);

  seq_state_e state;
  src_e       cur;
  logic       skip_q;

  logic       cur_done, cur_valid, cur_boot, expired;
  logic [5:0] cur_wbits;
  logic       probe_hit, probe_miss, last_src;

  assign cur_done  = probe_done[cur];
  assign cur_valid = probe_valid[cur];
  assign last_src  = (cur == SRC_NAND);

  bseq_sig_check i_sig (
    .src        (cur),
    .valid      (cur_valid),
    .width_code (probe_width),
    .bootable   (cur_boot),
    .width_out  (cur_wbits)
  );

  bseq_probe_timer #(.LIMIT(PROBE_TIMEOUT)) i_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (state == ST_PROBE),
    .expired (expired)
  );

  // Named events for the assertions below.
  assign probe_hit  = (state == ST_PROBE) && cur_done && cur_boot;
  assign probe_miss = (state == ST_PROBE) &&
                      ((cur_done && !cur_boot) || (!cur_done && expired));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_INIT;
      cur        <= SRC_UART;
      skip_q     <= 1'b0;
      sel_src    <= '0;
      exec_addr  <= '0;
      boot_width <= '0;
    end else begin
      case (state)
        ST_INIT: begin
          skip_q <= uart_boot_off;
          cur    <= first_source(uart_boot_off);
          state  <= ST_PROBE;
        end
        ST_PROBE: begin
          if (probe_hit) begin
            sel_src    <= cur;
            exec_addr  <= runs_in_place(cur) ? XIP_ENTRY : RAM_ENTRY;
            boot_width <= cur_wbits;
            state      <= runs_in_place(cur) ? ST_HANDOFF : ST_COPY_GO;
          end else if (probe_miss) begin
            state <= last_src ? ST_FAIL : ST_GAP;
          end
        end
        ST_GAP: begin
          cur   <= src_e'(cur + 1'b1);
          state <= ST_PROBE;
        end
        ST_COPY_GO:   state <= ST_COPY_WAIT;
        ST_COPY_WAIT: if (copy_done) state <= ST_HANDOFF;
        ST_HANDOFF:   state <= ST_DONE;
        default:      state <= state;
      endcase
    end
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_req
    assign probe_req[g] = (state == ST_PROBE) && (cur == src_e'(g));
  end

  assign copy_start = (state == ST_COPY_GO);
  assign start_exec = (state == ST_HANDOFF);
  assign boot_fail  = (state == ST_FAIL);

  AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(probe_req));  // R1
  AST_REQ_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    probe_miss |=> probe_req == '0);  // R1
  AST_UART_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_q && state != ST_INIT) |-> !probe_req[0]);  // R2
  AST_HIT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    probe_hit |=> probe_req == '0);  // R3
  AST_COPY_BEFORE_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    copy_start |=> !start_exec);  // R5
  AST_XIP_NO_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    (probe_hit && cur == SRC_NOR) |=> (start_exec && !copy_start));  // R6
  AST_EXEC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    start_exec |=> !start_exec);  // R7
  AST_HANDOFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DONE) |=> $stable({sel_src, exec_addr, boot_width}));  // R7
  AST_FAIL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    boot_fail |-> (probe_req == '0 && !start_exec && !copy_start));  // R8
  AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    boot_fail |=> boot_fail);  // R8

endmodule

// File: tb/test_boot_source_sequencer.sv
module test_boot_source_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int TMO        = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        uart_boot_off = 1'b0;
  logic [3:0]  probe_req;
  logic [3:0]  probe_done = '0;
  logic [3:0]  probe_valid = '0;
  logic [1:0]  probe_width = '0;
  logic        copy_start;
  logic        copy_done = 1'b0;
  logic [1:0]  sel_src;
  logic [31:0] exec_addr;
  logic [5:0]  boot_width;
  logic        start_exec;
  logic        boot_fail;

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_source_sequencer #(.PROBE_TIMEOUT(TMO)) i_boot_source_sequencer (
    .clk, .rst_n, .uart_boot_off, .probe_req, .probe_done, .probe_valid,
    .probe_width, .copy_start, .copy_done, .sel_src, .exec_addr,
    .boot_width, .start_exec, .boot_fail
  );

  int n_chk = 0;
  int n_bad = 0;

  // Responder config: 0 silent, 1 invalid, 2 valid.
  int mode [4];
  int dly  [4];

  // Observed results of one boot.
  logic [15:0] ord;
  int n_copy, n_exec, exec_gap, req_len [4];
  bit multi_req, stable_bad, fail_seen, fail_req;

  task automatic chk(input string rq, input string what, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, got, exp);
    end
  endtask

  task automatic cfg(input int m0, input int m1, input int m2, input int m3, input logic [1:0] wc);
    mode[0] = m0; mode[1] = m1; mode[2] = m2; mode[3] = m3;
    for (int k = 0; k < 4; k++) dly[k] = 2 + k;
    probe_width = wc;
  endtask

  task automatic run_boot(input bit strap, input bit noise);
    int age, cyc, trig_cyc, exec_cyc, tail, copy_cnt, idx;
    logic [3:0]  prev_req;
    logic [39:0] snap;
    rst_n = 1'b0; uart_boot_off = strap;
    probe_done = '0; probe_valid = '0; copy_done = 1'b0;
    repeat (3) @(negedge clk);
    ord = '0; n_copy = 0; n_exec = 0; exec_gap = -1;
    multi_req = 0; stable_bad = 0; fail_seen = 0; fail_req = 0;
    for (int k = 0; k < 4; k++) req_len[k] = 0;
    age = 0; cyc = 0; trig_cyc = -100; exec_cyc = -1; tail = -1;
    copy_cnt = -1; prev_req = '0; snap = '0; idx = 0;
    rst_n = 1'b1;
    while (cyc < 400 && tail != 0) begin
      @(negedge clk); cyc++;
      if ($countones(probe_req) > 1) multi_req = 1;
      for (int k = 0; k < 4; k++) if (probe_req[k]) begin req_len[k]++; idx = k; end
      if (probe_req != 0 && prev_req == 0) ord = {ord[11:0], 4'(idx + 1)};
      if (copy_start) begin n_copy++; copy_cnt = 3; end
      if (start_exec) begin
        n_exec++;
        if (exec_cyc < 0) begin
          exec_cyc = cyc; exec_gap = cyc - trig_cyc;
          snap = {sel_src, exec_addr, boot_width}; tail = 7;
        end
      end else if (exec_cyc >= 0 && snap !== {sel_src, exec_addr, boot_width}) stable_bad = 1;
      if (boot_fail) begin
        if (!fail_seen) tail = 7;
        fail_seen = 1;
        if (probe_req != 0) fail_req = 1;
      end else if (fail_seen) fail_req = 1;
      if (tail > 0) tail--;
      probe_done = '0; probe_valid = '0; copy_done = 1'b0;
      if (probe_req == 0) age = 0;
      else begin
        age++;
        if (mode[idx] != 0 && age == dly[idx]) begin
          probe_done[idx] = 1'b1; probe_valid[idx] = (mode[idx] == 2); trig_cyc = cyc;
        end
      end
      if (noise) begin probe_done |= ~probe_req; probe_valid |= ~probe_req; end
      if (copy_cnt > 0) begin
        copy_cnt--;
        if (copy_cnt == 0) begin copy_done = 1'b1; trig_cyc = cyc; end
      end
      prev_req = probe_req;
    end
    probe_done = '0; probe_valid = '0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9", "probe_req in reset", 64'(probe_req), 0);
    chk("R9", "copy/exec/fail in reset", {copy_start, start_exec, boot_fail}, 0);
    chk("R9", "handoff in reset", {sel_src, exec_addr, boot_width}, 0);
  endtask

  task automatic t_uart_first;
    cfg(2, 2, 2, 2, 2'd0);
    run_boot(0, 0);
    chk("R1", "order uart", 64'(ord), 16'h0001);
    chk("R3", "sel uart", 64'(sel_src), 0);
    chk("R5", "copy pulses", 64'(n_copy), 1);
    chk("R5", "ram entry/width", {exec_addr, boot_width}, {32'h0, 6'd32});
    chk("R7", "exec after copy_done", 64'(exec_gap), 1);
    chk("R7", "exec once + stable", {32'(n_exec), 31'(0), stable_bad}, {32'd1, 32'd0});
  endtask

  task automatic t_strap_skip;
    cfg(2, 2, 1, 1, 2'd0);
    run_boot(1, 0);
    chk("R2", "uart never requested", 64'(req_len[0]), 0);
    chk("R2", "order starts at spi", 64'(ord), 16'h0002);
    chk("R3", "sel spi", 64'(sel_src), 1);
  endtask

  task automatic t_nor_xip;
    cfg(1, 1, 2, 2, 2'd1);
    run_boot(0, 0);
    chk("R3", "order stops at nor", 64'(ord), 16'h0123);
    chk("R6", "no copy for nor", 64'(n_copy), 0);
    chk("R6", "xip entry/width16", {exec_addr, boot_width}, {32'hE000_0004, 6'd16});
    chk("R7", "exec after nor answer", 64'(exec_gap), 1);
    chk("R7", "stable after exec", 64'(stable_bad), 0);
  endtask

  task automatic t_nor_w32;
    cfg(1, 1, 2, 1, 2'd2);
    run_boot(0, 0);
    chk("R6", "xip width32", {sel_src, boot_width}, {2'd2, 6'd32});
  endtask

  task automatic t_nand_noise;
    cfg(1, 1, 1, 2, 2'd0);
    run_boot(0, 1);
    chk("R1", "full order", 64'(ord), 16'h1234);
    chk("R1", "one request at a time", 64'(multi_req), 0);
    chk("R3", "noise ignored, sel nand", 64'(sel_src), 3);
    chk("R5", "nand copied", {32'(n_copy), exec_addr}, {32'd1, 32'h0});
  endtask

  task automatic t_timeout;
    cfg(0, 2, 2, 2, 2'd0);
    run_boot(0, 0);
    chk("R4", "timed-out request length", 64'(req_len[0]), TMO);
    chk("R4", "falls through to spi", {ord, 14'(0), sel_src}, {16'h0012, 16'd1});
  endtask

  task automatic t_bad_width;
    cfg(1, 0, 2, 2, 2'd3);
    run_boot(0, 0);
    chk("R6", "width code 3 not bootable", 64'(ord), 16'h1234);
    chk("R6", "nand after bad nor", {sel_src, boot_width, 32'(n_copy)}, {2'd3, 6'd32, 32'd1});
  endtask

  task automatic t_all_fail;
    cfg(1, 1, 1, 0, 2'd3);
    run_boot(1, 0);
    chk("R8", "fail flag", 64'(fail_seen), 1);
    chk("R8", "quiet after fail", {32'(n_exec), 31'(0), fail_req}, 0);
    chk("R8", "tried spi..nand", 64'(ord), 16'h0234);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_uart_first();
    t_strap_skip();
    t_nor_xip();
    t_nor_w32();
    t_nand_noise();
    t_timeout();
    t_bad_width();
    t_all_fail();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule